// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is a slave on a two-wire serial bus (I2C-style clock and data lines) that fronts a 512-byte memory held in an ordinary register array. A master addresses it with a slave byte. That byte carries a fixed four-bit device code, two bits compared against strapping pins, one page bit that becomes the top memory address bit, and a direction bit. The block then either takes a word address and data bytes to store, or returns bytes from an internal address pointer for as long as the master keeps acknowledging.

The bus lines enter as plain inputs sampled on a fast system clock through synchronizers. The block pulls the data line low only through an open-drain enable (`sda_oe`): the board or bench forms the wired-AND line. Both bus pins are plain control pins. There is no back-pressure here: the serial clock from the master sets the pace, and the block always keeps up because the system clock is at least eight times faster than SCL.

Top module: `twi_eeprom`

## Requirements
- R1: SDA falling while SCL is high (start) is honoured in every state. It abandons any partial byte, so a data byte cut short by a start is never written, and a new slave byte follows.
- R2: SDA rising while SCL is high (stop) returns the block to idle with SDA released. Bytes clocked after a stop without a new start get no acknowledge.
- R3: The slave byte is taken MSB first. Bits 7..4 must be 1010 and bits 3..2 must equal `dev_sel[1:0]` (bit 3 against `dev_sel[1]`). Otherwise the block gives no acknowledge and ignores the bus until the next start.
- R4: The block drives SDA low for the ninth clock after a matching slave byte and after every received word-address or data byte.
- R5: With direction bit 0 = write, the next byte is the word address. The pointer becomes {slave bit 1, word address}. Each following data byte is stored at the pointer, and the pointer then advances by one.
- R6: Random read: a write slave byte and a word address, then a repeated start and a slave byte with bit 0 = 1, returns the byte stored at that address.
- R7: Read bytes continue in sequence while the master acknowledges (SDA low on the ninth clock). The pointer advances by one after each byte read or written and wraps from 511 to 0.
- R8: After a read byte that the master does not acknowledge, the block releases SDA and drives nothing until the next start or stop.
- R9: A read slave byte with no word address first returns the byte at the current pointer, which is one past the last byte accessed.
- R10: SDA drive changes only while SCL is low, so each bit stays steady for the whole SCL high phase.
- R11: After reset, SDA is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| dev_sel | input | 2 | Strapping pins compared with slave byte bits 3..2 |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus (wired-AND result) |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
The assertions assume a well-behaved master. The master changes SDA only while SCL is low, except when it makes a start or a stop, and it never makes a start or stop while the slave is pulling SDA. Every SCL high or low phase must also last several system clocks longer than the synchronizer delay, so that the drive changes made after a falling edge still land in the low phase. The bench master keeps to this. Each SCL quarter period lasts ten system clocks, SDA is moved only in the middle of the low phase, and starts and stops are issued only while the slave is not driving. That covers a mid-byte abort and a stop after a non-acknowledged read.

// File: rtl/twi_eeprom_pkg.sv
package twi_eeprom_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,   // ignoring the bus until start
    ST_DEV,    // shifting in the slave byte
    ST_WADDR,  // shifting in the word address
    ST_WDATA,  // shifting in write data
    ST_ACK,    // holding SDA low for the ninth clock
    ST_RDATA,  // shifting out a read byte
    ST_RACK    // sampling the master's acknowledge
  } st_e;
endpackage

// File: rtl/twi_eeprom_sync.sv
module twi_eeprom_sync #(
  parameter int SYNC_N = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [SYNC_N-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q, scl_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[SYNC_N-2:0], scl_i};
      sda_ff <= {sda_ff[SYNC_N-2:0], sda_i};
      scl_q  <= scl_ff[SYNC_N-1];
      sda_q  <= sda_ff[SYNC_N-1];
    end
  end

  assign scl_s     = scl_ff[SYNC_N-1];
  assign sda_s     = sda_ff[SYNC_N-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  // data moves while the clock stays high: a bus condition
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/twi_eeprom_mem.sv
module twi_eeprom_mem #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[addr] <= wdata;
  end

  assign rdata = cells[addr];
endmodule

// File: rtl/twi_eeprom_ctrl.sv
module twi_eeprom_ctrl
  import twi_eeprom_pkg::*;
#(
  parameter int         ADDR_W   = 9,
  parameter logic [3:0] DEV_CODE = 4'b1010,
  localparam int        PAGE_W   = ADDR_W - 8,
  localparam int        SEL_W    = 3 - PAGE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              sda_s,
  input  logic [SEL_W-1:0]  dev_sel,
  input  logic [7:0]        rd_data,
  output logic              wr_en,
  output logic [7:0]        wr_data,
  output logic [ADDR_W-1:0] ptr,
  output logic              sda_oe,
  output st_e               st
);
  st_e               st_q, ret_q;
  logic [3:0]        cnt_q;
  logic [7:0]        sh_q, tx_q;
  logic [PAGE_W-1:0] page_q;
  logic [ADDR_W-1:0] ptr_q;
  logic              oe_q, mack_q;
  logic              byte_done, dev_hit;

  assign byte_done = scl_fall && (cnt_q == 4'd8);
  assign dev_hit   = (sh_q[7:4] == DEV_CODE) && (sh_q[3 -: SEL_W] == dev_sel);
  assign wr_en     = (st_q == ST_WDATA) && byte_done;
  assign wr_data   = sh_q;
  assign ptr       = ptr_q;
  assign sda_oe    = oe_q;
  assign st        = st_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      ret_q  <= ST_IDLE;
      cnt_q  <= '0;
      sh_q   <= '0;
      tx_q   <= '0;
      page_q <= '0;
      ptr_q  <= '0;
      oe_q   <= 1'b0;
      mack_q <= 1'b0;
    end else if (start_det) begin
      st_q  <= ST_DEV;
      cnt_q <= '0;
      oe_q  <= 1'b0;
    end else if (stop_det) begin
      st_q <= ST_IDLE;
      oe_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_DEV, ST_WADDR, ST_WDATA: begin
          if (scl_rise && cnt_q != 4'd8) begin
            sh_q  <= {sh_q[6:0], sda_s};
            cnt_q <= cnt_q + 4'd1;
          end else if (byte_done) begin
            cnt_q <= '0;
            if (st_q == ST_DEV) begin
              if (dev_hit) begin
                page_q <= sh_q[PAGE_W:1];
                ret_q  <= sh_q[0] ? ST_RDATA : ST_WADDR;
                oe_q   <= 1'b1;
                st_q   <= ST_ACK;
              end else begin
                st_q <= ST_IDLE;
              end
            end else begin
              if (st_q == ST_WADDR) ptr_q <= {page_q, sh_q};
              else                  ptr_q <= ptr_q + ADDR_W'(1);
              ret_q <= ST_WDATA;
              oe_q  <= 1'b1;
              st_q  <= ST_ACK;
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            cnt_q <= '0;
            st_q  <= ret_q;
            if (ret_q == ST_RDATA) begin
              tx_q  <= rd_data;
              oe_q  <= ~rd_data[7];
              ptr_q <= ptr_q + ADDR_W'(1);
            end else begin
              oe_q <= 1'b0;
            end
          end
        end
        ST_RDATA: begin
          if (scl_fall) begin
            if (cnt_q == 4'd7) begin
              oe_q  <= 1'b0;
              cnt_q <= '0;
              st_q  <= ST_RACK;
            end else begin
              tx_q  <= {tx_q[6:0], 1'b0};
              oe_q  <= ~tx_q[6];
              cnt_q <= cnt_q + 4'd1;
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) mack_q <= ~sda_s;
          if (scl_fall) begin
            if (mack_q) begin
              tx_q  <= rd_data;
              oe_q  <= ~rd_data[7];
              ptr_q <= ptr_q + ADDR_W'(1);
              st_q  <= ST_RDATA;
            end else begin
              st_q <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/twi_eeprom.sv
module twi_eeprom
  import twi_eeprom_pkg::*;
#(
  parameter int         ADDR_W   = 9,
  parameter logic [3:0] DEV_CODE = 4'b1010,
  parameter int         SYNC_N   = 2,
  localparam int        SEL_W    = 11 - ADDR_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] dev_sel,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe
);
  logic              sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic              wr_en;
  logic [7:0]        wr_data, rd_data;
  logic [ADDR_W-1:0] ptr;
  st_e               ctrl_st;

  twi_eeprom_sync #(.SYNC_N(SYNC_N)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  twi_eeprom_ctrl #(.ADDR_W(ADDR_W), .DEV_CODE(DEV_CODE)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .sda_s(sda_s),
    .dev_sel(dev_sel), .rd_data(rd_data), .wr_en(wr_en),
    .wr_data(wr_data), .ptr(ptr), .sda_oe(sda_oe), .st(ctrl_st)
  );

  twi_eeprom_mem #(.ADDR_W(ADDR_W), .DATA_W(8)) u_mem (
    .clk(clk), .we(wr_en), .addr(ptr), .wdata(wr_data), .rdata(rd_data)
  );
endmodule

// File: rtl/twi_eeprom_chk.sv
module twi_eeprom_chk
  import twi_eeprom_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_i,
  input logic              sda_oe,
  input logic              start_det,
  input logic              stop_det,
  input st_e               ctrl_st,
  input logic [ADDR_W-1:0] ptr
);
  // R10: drive edges fall inside the SCL low phase
  assert_oe_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_i);

  // R1: a start always reopens the slave-byte phase with SDA released
  assert_start_restarts_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (ctrl_st == ST_DEV) && !sda_oe);

  // R2: a stop always idles the block with SDA released
  assert_stop_idles_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_det && !start_det) |=> (ctrl_st == ST_IDLE) && !sda_oe);

  // R8 and R3: nothing is driven while the bus is being ignored
  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_st == ST_IDLE || ctrl_st == ST_RACK) |-> !sda_oe);

  // R7: the pointer only steps by one (wrapping) unless a word address loads it
  assert_ptr_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ptr) |-> (ptr == ($past(ptr) + ADDR_W'(1))) || ($past(ctrl_st) == ST_WADDR));
endmodule

bind twi_eeprom twi_eeprom_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe),
  .start_det(start_det), .stop_det(stop_det), .ctrl_st(ctrl_st), .ptr(ptr)
);

// File: tb/sim_twi_eeprom.sv
`timescale 1ns/1ps
module sim_twi_eeprom;
  localparam int Q = 10;  // system clocks per SCL quarter period

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic [1:0] dev_sel = 2'b10;
  logic sda_oe;
  logic sda_line;
  int n_chk = 0;
  int n_fail = 0;

  assign sda_line = sda_m & ~sda_oe;

  always #4 clk = ~clk;

  twi_eeprom u0 (
    .clk(clk), .rst_n(rst_n), .dev_sel(dev_sel),
    .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_q;
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_bit(input logic b, output logic got, output logic steady);
    sda_m = b; wait_q;
    scl_m = 1'b1; wait_q;
    got = sda_line; wait_q;
    steady = (sda_line == got);
    scl_m = 1'b0; wait_q;
  endtask

  task automatic bus_start;
    sda_m = 1'b1; wait_q;
    scl_m = 1'b1; wait_q;
    sda_m = 1'b0; wait_q;
    scl_m = 1'b0; wait_q;
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; wait_q;
    scl_m = 1'b1; wait_q;
    sda_m = 1'b1; wait_q;
  endtask

  task automatic send_byte(input logic [7:0] d, output logic acked);
    logic g, s;
    for (int i = 7; i >= 0; i--) bus_bit(d[i], g, s);
    bus_bit(1'b1, g, s);
    acked = ~g;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] d, output logic steady);
    logic g, s;
    steady = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      bus_bit(1'b1, g, s);
      d[i] = g;
      steady &= s;
    end
    bus_bit(~mack, g, s);
  endtask

  task automatic t_reset;
    chk("R11 sda released after reset", sda_oe, 1'b0);
  endtask

  task automatic t_mismatch;
    logic a;
    bus_start;
    send_byte(8'hA4, a);  // pin bits 01 against strap 10
    chk("R3 wrong pins not acked", a, 1'b0);
    send_byte(8'h00, a);
    chk("R3 following byte ignored", a, 1'b0);
    bus_stop;
    bus_start;
    send_byte(8'hB8, a);  // device code 1011
    chk("R3 wrong code not acked", a, 1'b0);
    bus_stop;
    wait_q;
  endtask

  task automatic t_write;
    logic a;
    bus_start;
    send_byte(8'hA8, a); chk("R4 slave byte acked", a, 1'b1);
    send_byte(8'h23, a); chk("R4 word address acked", a, 1'b1);
    send_byte(8'hA5, a); chk("R5 data acked", a, 1'b1);
    send_byte(8'h5A, a); chk("R5 data acked", a, 1'b1);
    send_byte(8'hC3, a); chk("R5 data acked", a, 1'b1);
    bus_stop;
    wait_q;
  endtask

  task automatic t_random;
    logic a, s;
    logic [7:0] d;
    bus_start;
    send_byte(8'hA8, a);
    send_byte(8'h23, a);
    bus_start;
    send_byte(8'hA9, a); chk("R6 read slave byte acked", a, 1'b1);
    recv_byte(1'b0, d, s);
    chk("R6 random read data", d, 8'hA5);
    chk("R10 bits steady in SCL high", s, 1'b1);
    bus_stop;
    wait_q;
  endtask

  task automatic t_current;
    logic a, s;
    logic [7:0] d;
    bus_start;
    send_byte(8'hA9, a);
    recv_byte(1'b0, d, s);
    chk("R9 current address read", d, 8'h5A);
    bus_stop;
    wait_q;
  endtask

  task automatic t_seq_wrap;
    logic a, s;
    logic [7:0] d;
    bus_start;
    send_byte(8'hAA, a);  // page bit 1
    send_byte(8'hFE, a);
    send_byte(8'h11, a);
    send_byte(8'h22, a);
    send_byte(8'h33, a); chk("R7 write across wrap acked", a, 1'b1);
    send_byte(8'h44, a);
    bus_stop;
    wait_q;
    bus_start;
    send_byte(8'hAA, a);
    send_byte(8'hFE, a);
    bus_start;
    send_byte(8'hA9, a);
    recv_byte(1'b1, d, s); chk("R7 seq byte 0x1FE", d, 8'h11);
    recv_byte(1'b1, d, s); chk("R7 seq byte 0x1FF", d, 8'h22);
    recv_byte(1'b1, d, s); chk("R7 seq wraps to 0x000", d, 8'h33);
    recv_byte(1'b0, d, s); chk("R7 seq byte 0x001", d, 8'h44);
    recv_byte(1'b0, d, s); chk("R8 released after nack", d, 8'hFF);
    bus_stop;
    wait_q;
  endtask

  task automatic t_abort;
    logic a, g, s;
    logic [7:0] d;
    bus_start;
    send_byte(8'hA8, a);
    send_byte(8'h50, a);
    send_byte(8'h77, a);
    bus_stop;
    wait_q;
    bus_start;
    send_byte(8'hA8, a);
    send_byte(8'h50, a);
    for (int i = 0; i < 4; i++) bus_bit(1'b0, g, s);
    bus_start;  // cuts the data byte short
    send_byte(8'hA9, a); chk("R1 slave byte after restart acked", a, 1'b1);
    recv_byte(1'b0, d, s);
    chk("R1 partial byte not stored", d, 8'h77);
    bus_stop;
    wait_q;
  endtask

  task automatic t_stop;
    logic a;
    bus_start;
    send_byte(8'hA8, a);
    send_byte(8'h60, a);
    bus_stop;
    wait_q;
    scl_m = 1'b0; wait_q;
    send_byte(8'h00, a);
    chk("R2 byte after stop ignored", a, 1'b0);
    scl_m = 1'b1; wait_q;
    chk("R2 line released after stop", sda_oe, 1'b0);
    wait_q;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    wait_q;
    t_reset;
    t_mismatch;
    t_write;
    t_random;
    t_current;
    t_seq_wrap;
    t_abort;
    t_stop;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule